// File: doc/BRIEF.md
# Multicycle Load/Store Processor Step Controller

This block is the sequencing controller of a small multicycle processor whose datapath shares one memory for instructions and data and one ALU for all arithmetic. Rather than decoding an instruction once and finishing it in a single long cycle, the controller walks each instruction through short steps, one per clock. Each step uses at most one expensive resource: a memory access, a register-file access or an ALU operation. The datapath keeps intermediate results in its own holding registers between steps. These are the instruction register, a memory data register, the two operand latches and the ALU result latch.

The controller reads the 6-bit opcode field held in the instruction register and the ALU zero flag. It drives the per-step datapath controls: memory read and write, the memory address select, instruction register load, register destination select and write enable, ALU operand selects, the ALU operation class, the write-back source select, and the PC write enable and source. Four instruction classes are supported, and they take different numbers of cycles. Register-to-register ALU operations take 4 cycles, word loads 5, word stores 4 and branch-if-equal 3. Every instruction starts with a common fetch step and a common decode step. Control pins are plain levels. No stream interface is present, so there is no back-pressure.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high (sampled synchronously), every output is 0. After the first rising edge with `rst` high, the controller is in the fetch step, and it remains there until `rst` falls.
- R2: Fetch step: `mem_rd_o`=1, `addr_sel_o`=0 (PC), `ir_wr_o`=1, `alu_src_a_o`=0 (PC), `alu_src_b_o`=01 (constant 4), `alu_op_o`=00 (add), `pc_wr_o`=1, `pc_src_o`=0 (ALU result). The next step is always decode.
- R3: Decode step, which follows every fetch: no memory access and no write. `alu_src_a_o`=0 and `alu_src_b_o`=11 (shifted immediate) with `alu_op_o`=00, so that the branch target is formed.
- R4: Opcode 000000 (register ALU op) takes 4 cycles. Step 3 drives `alu_src_a_o`=1 (operand A), `alu_src_b_o`=00 (operand B) and `alu_op_o`=10 (function field). Step 4 drives `reg_wr_o`=1, `reg_dst_o`=1 (rd field) and `mem_to_reg_o`=0.
- R5: Opcode 100011 (load word) takes 5 cycles. Step 3 drives `alu_src_a_o`=1, `alu_src_b_o`=10 (immediate) and `alu_op_o`=00. Step 4 drives `mem_rd_o`=1 and `addr_sel_o`=1 (ALU result latch). Step 5 drives `reg_wr_o`=1, `reg_dst_o`=0 (rt field) and `mem_to_reg_o`=1.
- R6: Opcode 101011 (store word) takes 4 cycles. Step 3 is the same as load step 3. Step 4 drives `mem_wr_o`=1 and `addr_sel_o`=1. `reg_wr_o` stays 0 for the whole instruction.
- R7: Opcode 000100 (branch-if-equal) takes 3 cycles. Step 3 drives `alu_src_a_o`=1, `alu_src_b_o`=00, `alu_op_o`=01 (subtract) and `pc_src_o`=1 (target). In that step `pc_wr_o` equals `alu_zero_i`. The next step is fetch.
- R8: Any other opcode returns to fetch straight after decode, which gives a 2-cycle sequence with no write and no memory access.
- R9: `mem_rd_o` and `mem_wr_o` are never high in the same cycle. Outside the branch step, `alu_zero_i` has no effect on `pc_wr_o`.
- R10: Any control not named for a step in R2 to R8 is 0 in that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field from the instruction register |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU result latch |
| ir_wr_o | output | 1 | Instruction register load |
| reg_dst_o | output | 1 | Write register: 0 rt field, 1 rd field |
| reg_wr_o | output | 1 | Register file write enable |
| mem_to_reg_o | output | 1 | Write data: 0 ALU result latch, 1 memory data register |
| alu_src_a_o | output | 1 | ALU A input: 0 PC, 1 operand A |
| alu_src_b_o | output | 2 | ALU B input: 00 operand B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_op_o | output | 2 | ALU class: 00 add, 01 subtract, 10 use function field |
| pc_wr_o | output | 1 | PC write enable (final, zero-qualified) |
| pc_src_o | output | 1 | PC source: 0 ALU result, 1 ALU result latch (target) |

## Verification
Two things can fall in the same cycle. In fetch, the instruction register load and the PC increment are both driven from one memory read. In the branch step, the zero flag decides whether the PC is written while the ALU compares. The bench drives `alu_zero_i` high during fetch and during every non-branch step, as well as during the branch step. It then compares the full control vector in every cycle. So a PC write that appears outside fetch, or a fetch that lost either of its two writes, shows up as a miscompare. A reset asserted in the middle of a load checks that the sequence is abandoned and that the next instruction starts cleanly at fetch.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int OPC_W  = 6;
  localparam int AOP_W  = 2;
  localparam int SRCB_W = 2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_ADDR, ST_BRANCH,
    ST_MRD, ST_MWR, ST_WBR, ST_WBM
  } step_e;

  localparam logic [AOP_W-1:0]  AOP_ADD   = 2'b00;
  localparam logic [AOP_W-1:0]  AOP_SUB   = 2'b01;
  localparam logic [AOP_W-1:0]  AOP_FUNC  = 2'b10;
  localparam logic [SRCB_W-1:0] SRCB_REG  = 2'b00;
  localparam logic [SRCB_W-1:0] SRCB_FOUR = 2'b01;
  localparam logic [SRCB_W-1:0] SRCB_IMM  = 2'b10;
  localparam logic [SRCB_W-1:0] SRCB_IMMS = 2'b11;

  typedef struct packed {
    logic              mem_rd;
    logic              mem_wr;
    logic              addr_sel;
    logic              ir_wr;
    logic              reg_dst;
    logic              reg_wr;
    logic              mem_to_reg;
    logic              src_a;
    logic [SRCB_W-1:0] src_b;
    logic [AOP_W-1:0]  alu_op;
    logic              pc_wr;
    logic              pc_wr_cond;
    logic              pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100
) (
  input  step_e            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_e            nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_RTYPE)                          nxt = ST_EXEC;
        else if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
        else if (opcode == OP_BEQ)                        nxt = ST_BRANCH;
        else                                              nxt = ST_FETCH;
      end
      ST_EXEC:   nxt = ST_WBR;
      ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_MRD : ST_MWR;
      ST_MRD:    nxt = ST_WBM;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_out.sv
module mcyc_out
  import mcyc_pkg::*;
(
  input  step_e cur,
  output ctrl_t raw
);
  always_comb begin
    raw = '0;
    unique case (cur)
      ST_FETCH: begin
        raw.mem_rd = 1'b1;
        raw.ir_wr  = 1'b1;
        raw.src_b  = SRCB_FOUR;
        raw.alu_op = AOP_ADD;
        raw.pc_wr  = 1'b1;
      end
      ST_DECODE: raw.src_b = SRCB_IMMS;
      ST_EXEC: begin
        raw.src_a  = 1'b1;
        raw.src_b  = SRCB_REG;
        raw.alu_op = AOP_FUNC;
      end
      ST_ADDR: begin
        raw.src_a  = 1'b1;
        raw.src_b  = SRCB_IMM;
      end
      ST_BRANCH: begin
        raw.src_a      = 1'b1;
        raw.alu_op     = AOP_SUB;
        raw.pc_wr_cond = 1'b1;
        raw.pc_src     = 1'b1;
      end
      ST_MRD: begin
        raw.mem_rd   = 1'b1;
        raw.addr_sel = 1'b1;
      end
      ST_MWR: begin
        raw.mem_wr   = 1'b1;
        raw.addr_sel = 1'b1;
      end
      ST_WBR: begin
        raw.reg_wr  = 1'b1;
        raw.reg_dst = 1'b1;
      end
      ST_WBM: begin
        raw.reg_wr     = 1'b1;
        raw.mem_to_reg = 1'b1;
      end
      default: raw = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_gate.sv
module mcyc_gate
  import mcyc_pkg::*;
(
  input  logic  rst,
  input  logic  zero,
  input  ctrl_t raw,
  output ctrl_t fin,
  output logic  pc_en
);
  always_comb begin
    fin   = rst ? '0 : raw;
    pc_en = !rst && (raw.pc_wr || (raw.pc_wr_cond && zero));
  end

  always_comb begin
    AST_MEM_EXCL: assert (!(fin.mem_rd && fin.mem_wr)); // R9
    if (rst) begin
      AST_RST_QUIET: assert (fin == '0 && !pc_en); // R1
    end
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              alu_zero_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              addr_sel_o,
  output logic              ir_wr_o,
  output logic              reg_dst_o,
  output logic              reg_wr_o,
  output logic              mem_to_reg_o,
  output logic              alu_src_a_o,
  output logic [SRCB_W-1:0] alu_src_b_o,
  output logic [AOP_W-1:0]  alu_op_o,
  output logic              pc_wr_o,
  output logic              pc_src_o
);
  step_e cur, nxt;
  ctrl_t raw, fin;
  logic  pc_en;

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_FETCH;
    else     cur <= nxt;
  end

  mcyc_next #(
    .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)
  ) u_next (.cur(cur), .opcode(opcode_i), .nxt(nxt));

  mcyc_out  u_out  (.cur(cur), .raw(raw));

  mcyc_gate u_gate (.rst(rst), .zero(alu_zero_i), .raw(raw), .fin(fin), .pc_en(pc_en));

  assign mem_rd_o     = fin.mem_rd;
  assign mem_wr_o     = fin.mem_wr;
  assign addr_sel_o   = fin.addr_sel;
  assign ir_wr_o      = fin.ir_wr;
  assign reg_dst_o    = fin.reg_dst;
  assign reg_wr_o     = fin.reg_wr;
  assign mem_to_reg_o = fin.mem_to_reg;
  assign alu_src_a_o  = fin.src_a;
  assign alu_src_b_o  = fin.src_b;
  assign alu_op_o     = fin.alu_op;
  assign pc_wr_o      = pc_en;
  assign pc_src_o     = fin.pc_src;

  logic opc_known;
  assign opc_known = (opcode_i == OP_RTYPE) || (opcode_i == OP_LOAD) ||
                     (opcode_i == OP_STORE) || (opcode_i == OP_BEQ);

  AST_RESET_FETCH: assert property (@(posedge clk) rst |=> cur == ST_FETCH); // R1
  AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst)
    cur == ST_FETCH |=> cur == ST_DECODE); // R2
  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
    cur == ST_WBM |-> $past(cur) == ST_MRD); // R5
  AST_STORE_DONE: assert property (@(posedge clk) disable iff (rst)
    cur == ST_MWR |=> cur == ST_FETCH); // R6
  AST_BR_RETURN: assert property (@(posedge clk) disable iff (rst)
    cur == ST_BRANCH |=> cur == ST_FETCH); // R7
  AST_BAD_OPC: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DECODE && !opc_known) |=> cur == ST_FETCH); // R8
  AST_NO_STORE_WB: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> !reg_wr_o); // R6
endmodule

// File: tb/tb_mcyc_ctrl.sv
module tb_mcyc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b000000;
  logic       zero = 1'b0;
  logic       mem_rd, mem_wr, addr_sel, ir_wr, reg_dst, reg_wr, m2r, src_a, pc_wr, pc_src;
  logic [1:0] src_b, alu_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [13:0] q_v[$];
  string       q_t[$];

  always #2.5 clk = ~clk;

  mcyc_ctrl dut (
    .clk(clk), .rst(rst), .opcode_i(opcode), .alu_zero_i(zero),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .addr_sel_o(addr_sel), .ir_wr_o(ir_wr),
    .reg_dst_o(reg_dst), .reg_wr_o(reg_wr), .mem_to_reg_o(m2r),
    .alu_src_a_o(src_a), .alu_src_b_o(src_b), .alu_op_o(alu_op),
    .pc_wr_o(pc_wr), .pc_src_o(pc_src)
  );

  // vector order: mem_rd mem_wr addr_sel ir_wr reg_dst reg_wr m2r src_a src_b alu_op pc_wr pc_src
  function automatic logic [13:0] mk(bit mr, bit mw, bit as, bit ir, bit rd, bit rw,
                                     bit mt, bit sa, bit [1:0] sb, bit [1:0] op, bit pw, bit ps);
    return {mr, mw, as, ir, rd, rw, mt, sa, sb, op, pw, ps};
  endfunction

  task automatic push(logic [13:0] v, string t);
    q_v.push_back(v);
    q_t.push_back(t);
  endtask

  // Called at posedge+1; pushes the expected steps and waits them out.
  task automatic run_instr(logic [5:0] op, bit z, int upto);
    logic [13:0] seq[5];
    string       tag[5];
    int          n;
    opcode = op;
    zero   = z;
    seq[0] = mk(1,0,0,1,0,0,0,0,2'b01,2'b00,1,0); tag[0] = "R2/R10";
    seq[1] = mk(0,0,0,0,0,0,0,0,2'b11,2'b00,0,0); tag[1] = "R3/R10";
    n = 2;
    if (op == 6'b000000) begin
      seq[2] = mk(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0); tag[2] = "R4";
      seq[3] = mk(0,0,0,0,1,1,0,0,2'b00,2'b00,0,0); tag[3] = "R4";
      n = 4;
    end else if (op == 6'b100011) begin
      seq[2] = mk(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0); tag[2] = "R5";
      seq[3] = mk(1,0,1,0,0,0,0,0,2'b00,2'b00,0,0); tag[3] = "R5";
      seq[4] = mk(0,0,0,0,0,1,1,0,2'b00,2'b00,0,0); tag[4] = "R5";
      n = 5;
    end else if (op == 6'b101011) begin
      seq[2] = mk(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0); tag[2] = "R6";
      seq[3] = mk(0,1,1,0,0,0,0,0,2'b00,2'b00,0,0); tag[3] = "R6";
      n = 4;
    end else if (op == 6'b000100) begin
      seq[2] = mk(0,0,0,0,0,0,0,1,2'b00,2'b01,z,1); tag[2] = "R7";
      n = 3;
    end else begin
      tag[0] = "R8"; tag[1] = "R8";
    end
    if (upto > 0 && upto < n) n = upto;
    for (int i = 0; i < n; i++) push(seq[i], tag[i]);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apply_reset(int cyc);
    rst = 1'b1;
    for (int i = 0; i < cyc; i++) push(14'd0, "R1");
    repeat (cyc) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    logic [13:0] act, exp_v;
    string t;
    act = {mem_rd, mem_wr, addr_sel, ir_wr, reg_dst, reg_wr, m2r, src_a, src_b, alu_op, pc_wr, pc_src};
    if (q_v.size() > 0) begin
      exp_v = q_v.pop_front();
      t     = q_t.pop_front();
      checks++;
      if (act !== exp_v) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, act, exp_v);
      end
    end
    if (!rst) begin
      checks++;
      if (mem_rd && mem_wr) begin
        fails++;
        $display("FAIL R9: mem_rd=%b mem_wr=%b expected not both 1", mem_rd, mem_wr);
      end
    end
  end

  initial begin
    @(posedge clk);
    #1;
    apply_reset(3);                      // R1 reset state
    run_instr(6'b000000, 1'b0, 0);       // R4
    run_instr(6'b000000, 1'b1, 0);       // R4, R9 zero ignored outside branch
    run_instr(6'b100011, 1'b1, 0);       // R5
    run_instr(6'b101011, 1'b1, 0);       // R6
    run_instr(6'b000100, 1'b1, 0);       // R7 taken
    run_instr(6'b000100, 1'b0, 0);       // R7 not taken
    run_instr(6'b111111, 1'b1, 0);       // R8
    run_instr(6'b000010, 1'b0, 0);       // R8
    run_instr(6'b100011, 1'b0, 3);       // load cut short by reset
    apply_reset(2);                      // R1 mid-instruction
    run_instr(6'b101011, 1'b0, 0);       // R6 after reset
    run_instr(6'b100011, 1'b0, 0);       // R5
    run_instr(6'b000100, 1'b1, 0);       // R7
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule